// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM Model

This block is a synthesizable, cycle-accurate model of a synchronous static RAM whose data bus never needs an idle cycle when traffic switches between reading and writing. The array holds 256 words of 18 bits, organised as two 9-bit bytes. A static mode pin chooses between a pipelined read path, which adds an output register, and a flow-through read path. Write data always trails its command: by two cycles in pipelined mode and by one cycle in flow-through mode. Because of this, the slot where a read would drive the bus and the slot where a write would receive data never fall in the same cycle.

A controller issues a command on each rising edge. A command is a read, a write, a burst continuation or a deselect. A burst runs for four beats, and its address sequence is linear or interleaved according to a static pin. Writes whose data has not yet arrived wait in a two-slot queue. A read that targets the entry receiving its data on the same edge gets that data, merged byte by byte with the stored word. Each enabled byte of incoming write data is checked for parity, with even or odd parity chosen by a static pin. An asynchronous output enable can silence the data outputs at any time. The tri-state bus is modelled as a separate input bus, output bus and drive flag.

The command state machine has three states:
- `ST_IDLE`: deselected.
- `ST_RD`: a read burst is in progress.
- `ST_WR`: a write burst is in progress.

Its transitions are:
- read start: a new command with `we_n` high moves to `ST_RD`.
- write start: a new command with `we_n` low moves to `ST_WR`.
- burst continue: `burst_next` high keeps the current state and advances the beat.
- deselect: with `burst_next` low and any enable inactive, the machine goes to `ST_IDLE`.

A read start or a write start may also be taken directly from `ST_RD` or `ST_WR`.

Top module: `nt_sram`

## Requirements
- R1: A new command is accepted only when `en_a_n` is 0, `en_b` is 1 and `en_c_n` is 0 together. Otherwise, with `burst_next` low, the cycle is a deselect: nothing is written and nothing is driven. A `burst_next` that follows a deselect is also a deselect.
- R2: In pipelined mode (`pipe_mode` = 1), the data for a read sampled at edge k is driven from edge k+1 until edge k+2.
- R3: In flow-through mode (`pipe_mode` = 0), the data for a read sampled at edge k is driven from edge k until edge k+1.
- R4: The data for a write sampled at edge k is captured from `dq_in` at edge k+2 in pipelined mode and at edge k+1 in flow-through mode.
- R5: Reads and writes may alternate on consecutive edges in any order, with no idle cycle, and every read returns the correct word.
- R6: `bw_n[0]` (active low) enables bits 8:0 and `bw_n[1]` enables bits 17:9. A disabled byte keeps its stored value. The enables are sampled with each command or burst beat.
- R7: With `lin_order` = 1, beat n of a burst uses the start address with its low two bits replaced by (start low bits + n) mod 4.
- R8: With `lin_order` = 0, beat n uses the start address with its low two bits XORed with n.
- R9: While `oe_n` is 1, `dq_oe` is 0, whatever the synchronous state.
- R10: In pipelined mode, a read issued on the edge right after a write to the same address returns the new data for the enabled bytes and the stored data for the others.
- R11: For every enabled byte being captured, the XOR of its 9 bits must equal `odd_par`. On a mismatch, `par_err` is 1 during the cycle that ends with the capture edge, and the write is still performed.
- R12: While `rst_n` is 0 and after its release, `dq_oe` and `par_err` are 0 until a command produces them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pipe_mode | input | 1 | Static: 1 pipelined reads, 0 flow-through |
| lin_order | input | 1 | Static: 1 linear burst, 0 interleaved |
| odd_par | input | 1 | Static: 1 odd parity, 0 even parity |
| en_a_n | input | 1 | Chip enable, active low |
| en_b | input | 1 | Chip enable, active high |
| en_c_n | input | 1 | Chip enable, active low |
| burst_next | input | 1 | Continue the current burst with the next beat |
| we_n | input | 1 | 0 write, 1 read for a new command |
| bw_n | input | 2 | Per-byte write enables, active low |
| addr | input | 8 | Word address |
| dq_in | input | 18 | Write data bus |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_out | output | 18 | Read data bus |
| dq_oe | output | 1 | 1 while `dq_out` is driven |
| par_err | output | 1 | Parity mismatch on data being captured |

## Verification
In pipelined mode, the late data capture of one write and the array read for a following read command fall on the same edge. When the addresses match, the read has to be served from `dq_in` rather than from the array. The bench provokes this by issuing a write, full-word or single-byte, and on the very next edge a read of the same address. It judges the result against a reference memory that is updated when each command issues, so a correct read shows the merged bytes in the drive window R2 predicts. Parity checking runs on that same capture edge, so bad-parity writes are placed in these sequences as well. They must raise `par_err` in the capture cycle while the data still lands.

// File: rtl/nt_pkg.sv
`timescale 1ns/1ps
package nt_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } nt_state_e;

    function automatic logic [BEAT_W-1:0] beat_addr(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              lin
    );
        return lin ? (start + beat) : (start ^ beat);
    endfunction

endpackage

// File: rtl/nt_cmd_fsm.sv
`timescale 1ns/1ps
module nt_cmd_fsm
    import nt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lin_order,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              burst_next,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_rd,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_be
);

    nt_state_e         state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [ADDR_W-1:0] base_q, base_d;
    logic              sel;

    // next-state: read start, write start, burst continue, deselect
    always_comb begin
        sel     = !en_a_n && en_b && !en_c_n;
        state_d = state_q;
        beat_d  = beat_q;
        base_d  = base_q;
        if (burst_next) begin
            beat_d = beat_q + 1'b1;
        end else if (sel) begin
            state_d = we_n ? ST_RD : ST_WR;
            beat_d  = '0;
            base_d  = addr;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        cmd_rd   = 1'b0;
        cmd_wr   = 1'b0;
        cmd_addr = {base_d[ADDR_W-1:BEAT_W],
                    beat_addr(base_d[BEAT_W-1:0], beat_d, lin_order)};
        cmd_be   = ~bw_n;
        unique case (state_d)
            ST_IDLE: ;
            ST_RD:   cmd_rd = 1'b1;
            ST_WR:   cmd_wr = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nt_wr_queue.sv
`timescale 1ns/1ps
module nt_wr_queue #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int DATA_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              odd_par,
    input  logic              cmd_rd,
    input  logic              cmd_wr,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [NBYTES-1:0] cmd_be,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [NBYTES-1:0] wr_be,
    output logic [NBYTES-1:0] fwd_be,
    output logic              par_err
);

    typedef struct packed {
        logic              rd;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [NBYTES-1:0] be;
    } slot_t;

    slot_t             s1_q, s2_q;
    logic [NBYTES-1:0] byte_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= '{rd: cmd_rd, wr: cmd_wr, addr: cmd_addr, be: cmd_be};
            s2_q <= s1_q;
        end
    end

    always_comb begin
        rd_en   = s1_q.rd;
        rd_addr = s1_q.addr;
        if (pipe_mode) begin
            wr_en   = s2_q.wr;
            wr_addr = s2_q.addr;
            wr_be   = s2_q.be;
        end else begin
            wr_en   = s1_q.wr;
            wr_addr = s1_q.addr;
            wr_be   = s1_q.be;
        end
        fwd_be = (pipe_mode && s2_q.wr && s1_q.rd && (s2_q.addr == s1_q.addr))
                 ? s2_q.be : '0;
    end

    for (genvar b = 0; b < NBYTES; b++) begin : g_par
        assign byte_bad[b] = wr_be[b] &&
                             ((^dq_in[b*BYTE_W +: BYTE_W]) != odd_par);
    end

    assign par_err = wr_en && (|byte_bad);

endmodule

// File: rtl/nt_array.sv
`timescale 1ns/1ps
module nt_array #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int DATA_W = BYTE_W * NBYTES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NBYTES-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NBYTES-1:0] fwd_be,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (wr_be[b]) begin
                    mem[wr_addr][b*BYTE_W +: BYTE_W] <= wr_data[b*BYTE_W +: BYTE_W];
                end
            end
        end
    end

    always_comb begin
        rd_word = mem[rd_addr];
        for (int b = 0; b < NBYTES; b++) begin
            if (fwd_be[b]) begin
                rd_word[b*BYTE_W +: BYTE_W] = wr_data[b*BYTE_W +: BYTE_W];
            end
        end
    end

endmodule

// File: rtl/nt_sram.sv
`timescale 1ns/1ps
module nt_sram #(
    parameter int ADDR_W = 8,
    parameter int BYTE_W = 9,
    parameter int NBYTES = 2,
    localparam int DATA_W = BYTE_W * NBYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              lin_order,
    input  logic              odd_par,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              burst_next,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bw_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              par_err
);

    logic              cmd_rd, cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [NBYTES-1:0] cmd_be;
    logic              rd_en, wr_en;
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [NBYTES-1:0] wr_be, fwd_be;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] out_q;
    logic              out_v;
    logic              drive;

    nt_cmd_fsm #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .lin_order(lin_order),
        .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_next(burst_next), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be)
    );

    nt_wr_queue #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_wq (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .odd_par(odd_par),
        .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
        .dq_in(dq_in), .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_be(wr_be), .fwd_be(fwd_be), .par_err(par_err)
    );

    nt_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_arr (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
        .wr_data(dq_in), .rd_addr(rd_addr), .fwd_be(fwd_be), .rd_word(rd_word)
    );

    // pipelined output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else begin
            out_v <= rd_en;
            out_q <= rd_word;
        end
    end

    always_comb begin
        if (pipe_mode) begin
            dq_out = out_q;
            drive  = out_v;
        end else begin
            dq_out = rd_word;
            drive  = rd_en;
        end
        dq_oe = drive && !oe_n;
    end

endmodule

// File: rtl/nt_sram_chk.sv
`timescale 1ns/1ps
module nt_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic pipe_mode,
    input logic en_a_n,
    input logic en_b,
    input logic en_c_n,
    input logic burst_next,
    input logic oe_n,
    input logic cmd_rd,
    input logic cmd_wr,
    input logic dq_oe,
    input logic par_err
);

    logic [1:0] seen;

    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    p_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!burst_next && !(!en_a_n && en_b && !en_c_n)) |-> !(cmd_rd || cmd_wr));

    p_pipe_read_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && cmd_rd) |-> ##2 (dq_oe || oe_n));

    p_pipe_drive_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && pipe_mode && dq_oe) |-> $past(cmd_rd, 2));

    p_flow_read_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pipe_mode && cmd_rd) |=> (dq_oe || oe_n));

    p_flow_drive_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && !pipe_mode && dq_oe) |-> $past(cmd_rd));

    p_oe_silences_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

    p_par_pipe_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && pipe_mode && par_err) |-> $past(cmd_wr, 2));

    p_par_flow_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && !pipe_mode && par_err) |-> $past(cmd_wr));

endmodule

bind nt_sram nt_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
    .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .burst_next(burst_next),
    .oe_n(oe_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .dq_oe(dq_oe), .par_err(par_err)
);

// File: tb/nt_sram_bench.sv
`timescale 1ns/1ps
module nt_sram_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pipe_mode = 1'b1, lin_order = 1'b1, odd_par = 1'b0;
    logic        en_a_n = 1'b1, en_b = 1'b0, en_c_n = 1'b1;
    logic        burst_next = 1'b0, we_n = 1'b1, oe_n = 1'b0;
    logic [1:0]  bw_n = 2'b11;
    logic [7:0]  addr = '0;
    logic [17:0] dq_in = '0;
    logic [17:0] dq_out;
    logic        dq_oe, par_err;

    always #10 clk = ~clk;

    nt_sram u_nt_sram (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .lin_order(lin_order),
        .odd_par(odd_par), .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n),
        .burst_next(burst_next), .we_n(we_n), .bw_n(bw_n), .addr(addr),
        .dq_in(dq_in), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe),
        .par_err(par_err)
    );

    typedef struct {
        int          win;
        bit          is_rd;
        bit          masked;
        logic [17:0] data;
        string       req;
    } exp_t;

    exp_t        sb[$];
    logic [17:0] data_at[int];
    bit          oe_hi[int];
    logic [17:0] refm[256];
    int          ecnt = 0;
    int          nchk = 0, nerr = 0;
    bit          mon_on = 0, done = 0;
    int          m_op = 0;
    logic [7:0]  m_base = '0;
    logic [1:0]  m_beat = '0;

    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic chk(input bit ok, input string req, input logic [17:0] act, input logic [17:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h (edge %0d)", req, act, expv, ecnt);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    endtask

    // monitor: pops scoreboard items for the current window
    always begin : mon
        bit   got_rd, got_par;
        exp_t r;
        @(posedge clk);
        #15;
        if (mon_on) begin
            got_rd = 0;
            got_par = 0;
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].win == ecnt) begin
                    if (sb[i].is_rd) begin got_rd = 1; r = sb[i]; end
                    else got_par = 1;
                    sb.delete(i);
                end
            end
            if (got_rd) begin
                if (r.masked) chk(dq_oe == 1'b0, "R9 oe_n silences", {17'b0, dq_oe}, 18'h0);
                else chk(dq_oe && dq_out == r.data, r.req, dq_out, r.data);
            end else begin
                chk(dq_oe == 1'b0, "R1 no drive without read", {17'b0, dq_oe}, 18'h0);
            end
            chk(par_err == got_par, "R11 parity flag", {17'b0, par_err}, {17'b0, got_par});
        end
    end

    function automatic logic [17:0] gp(input logic [17:0] v);
        logic [17:0] o = v;
        o[8]  = (^v[7:0])  ^ odd_par;
        o[17] = (^v[16:9]) ^ odd_par;
        return o;
    endfunction

    task automatic tick(input bit adv_i, input bit [2:0] ce_ok, input bit wr_i,
                        input logic [7:0] a, input logic [1:0] be,
                        input logic [17:0] wd, input bit mask, input string req);
        int          id, dwin, rwin;
        logic [7:0]  ea;
        bit          bad;
        @(negedge clk);
        id = ecnt + 1;
        if (adv_i) m_beat = m_beat + 2'd1;
        else if (&ce_ok) begin m_op = wr_i ? 2 : 1; m_base = a; m_beat = '0; end
        else m_op = 0;
        ea = {m_base[7:2], lin_order ? (m_base[1:0] + m_beat) : (m_base[1:0] ^ m_beat)};
        if (m_op == 2) begin
            dwin = pipe_mode ? id + 1 : id;
            data_at[dwin] = wd;
            if (be[0]) refm[ea][8:0]  = wd[8:0];
            if (be[1]) refm[ea][17:9] = wd[17:9];
            bad = (be[0] && ((^wd[8:0]) != odd_par)) || (be[1] && ((^wd[17:9]) != odd_par));
            if (bad) sb.push_back('{dwin, 1'b0, 1'b0, 18'h0, "R11"});
        end else if (m_op == 1) begin
            rwin = pipe_mode ? id + 1 : id;
            if (mask) oe_hi[rwin] = 1;
            sb.push_back('{rwin, 1'b1, mask, refm[ea], req});
        end
        burst_next = adv_i;
        en_a_n = !ce_ok[0];
        en_b   = ce_ok[1];
        en_c_n = !ce_ok[2];
        we_n   = !wr_i;
        addr   = a;
        bw_n   = ~be;
        dq_in  = data_at.exists(ecnt) ? data_at[ecnt] : 18'h0;
        oe_n   = oe_hi.exists(ecnt);
    endtask

    task automatic wr(input logic [7:0] a, input logic [1:0] be, input logic [17:0] d, input string req);
        tick(0, 3'b111, 1, a, be, d, 0, req);
    endtask
    task automatic rd(input logic [7:0] a, input string req);
        tick(0, 3'b111, 0, a, 2'b11, 18'h0, 0, req);
    endtask
    task automatic nx(input logic [17:0] d, input string req);
        tick(1, 3'b111, 0, 8'h00, 2'b11, d, 0, req);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 3'b000, 0, 8'h00, 2'b11, 18'h0, 0, "R1");
    endtask

    task automatic do_reset(input bit p, input bit l, input bit o);
        @(negedge clk);
        mon_on = 0;
        rst_n = 0;
        pipe_mode = p; lin_order = l; odd_par = o;
        en_a_n = 1; en_b = 0; en_c_n = 1; burst_next = 0; oe_n = 0; dq_in = '0;
        sb.delete(); data_at.delete(); oe_hi.delete();
        m_op = 0;
        repeat (3) @(negedge clk);
        chk(dq_oe == 1'b0 && par_err == 1'b0, "R12 reset quiet", {16'b0, dq_oe, par_err}, 18'h0);
        rst_n = 1;
        mon_on = 1;
        @(negedge clk);
        chk(dq_oe == 1'b0 && par_err == 1'b0, "R12 after reset", {16'b0, dq_oe, par_err}, 18'h0);
    endtask

    task automatic suite();
        string burst_req;
        burst_req = lin_order ? "R7 linear burst" : "R8 interleaved burst";
        wr(8'h10, 2'b11, gp(18'h0_1234), "R4");
        wr(8'h11, 2'b11, gp(18'h2_5a5a), "R4");
        rd(8'h10, pipe_mode ? "R2 pipelined read" : "R3 flow read");
        rd(8'h11, pipe_mode ? "R2 pipelined read" : "R3 flow read");
        // alternation with no idle cycle
        wr(8'h12, 2'b11, gp(18'h1_0f0f), "R5");
        rd(8'h10, "R5 alternating");
        wr(8'h13, 2'b11, gp(18'h3_3c3c), "R5");
        rd(8'h12, "R5 alternating");
        wr(8'h14, 2'b11, gp(18'h0_7777), "R10");
        rd(8'h14, "R10 read of pending write");
        rd(8'h13, "R5 alternating");
        // byte writes
        wr(8'h10, 2'b01, gp(18'h3_ffff), "R6");
        rd(8'h10, "R6/R10 low byte merge");
        wr(8'h11, 2'b10, gp(18'h1_1111), "R6");
        idle(1);
        rd(8'h11, "R6 high byte only");
        // burst write from 0x31, then single reads and a burst read
        wr(8'h31, 2'b11, gp(18'h0_0a0a), burst_req);
        nx(gp(18'h0_0b0b), burst_req);
        nx(gp(18'h0_0c0c), burst_req);
        nx(gp(18'h0_0d0d), burst_req);
        idle(2);
        rd(8'h30, burst_req); rd(8'h31, burst_req);
        rd(8'h32, burst_req); rd(8'h33, burst_req);
        rd(8'h32, burst_req);
        nx(18'h0, burst_req); nx(18'h0, burst_req); nx(18'h0, burst_req);
        // deselects: each enable in turn, then a burst continue after deselect
        tick(0, 3'b110, 1, 8'h10, 2'b11, gp(18'h0_0001), 0, "R1");
        tick(0, 3'b101, 1, 8'h10, 2'b11, gp(18'h0_0002), 0, "R1");
        tick(0, 3'b011, 0, 8'h10, 2'b11, 18'h0, 0, "R1");
        tick(1, 3'b111, 1, 8'h10, 2'b11, gp(18'h0_0003), 0, "R1");
        idle(1);
        rd(8'h10, "R1 deselect left word intact");
        // parity: bad enabled byte, bad disabled byte
        wr(8'h20, 2'b11, gp(18'h2_4680) ^ 18'h0_0001, "R11");
        wr(8'h21, 2'b01, gp(18'h0_1357) ^ 18'h0_0200, "R11");
        rd(8'h20, "R11 write performed despite parity");
        idle(1);
        rd(8'h21, "R11 enabled byte written");
        // asynchronous output enable
        tick(0, 3'b111, 0, 8'h10, 2'b11, 18'h0, 1, "R9");
        rd(8'h11, "R9 drive restored");
        idle(5);
        chk(sb.size() == 0, "R5 scoreboard drained", 18'(sb.size()), 18'h0);
    endtask

    initial begin
        #(20 * 100000);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        do_reset(1, 1, 0);
        suite();
        do_reset(0, 0, 1);
        suite();
        do_reset(1, 0, 1);
        suite();
        summary();
    end

endmodule